// File: doc/BRIEF.md
# Burst Word Address Sequencer

This block produces the word address that a synchronous burst memory applies to its array on each beat. A start address is loaded when either of two address strobes is asserted: one is driven by the processor, the other by the memory controller. After the load, the block generates the following addresses itself. Only the two least significant bits are sequenced. The upper bits keep the loaded value until the next load.

An advance input controls stepping. While it is high, the block moves one beat on every clock, which supports a 3-1-1-1 access pattern. While it is low, the address is held and the memory waits. A static order pin selects between two sequences. The interleaved sequence XORs the start bits with the beat count. The linear sequence adds the beat count to the start bits and wraps inside the aligned four-word block. If a strobe arrives during a burst, the block reloads the address and starts a new burst.

Top module: `bam_burst_addr`

## Requirements
- R1: While rst_ni is low, and after it is released with no strobe, addr_o is all zeros.
- R2: On a rising clock edge where strobe_proc_i or strobe_ctrl_i (or both) is high, addr_i is captured and the beat count is cleared. From the next cycle, addr_o equals the captured address exactly.
- R3: When mode_lin_i = 0 (interleaved order), addr_o[1:0] equals the captured low bits XOR the beat count. For example, start 1 gives 1,0,3,2.
- R4: When mode_lin_i = 1 (linear order), addr_o[1:0] equals the captured low bits plus the beat count, modulo 4. For example, start 1 gives 1,2,3,0.
- R5: On each edge with advance_i high and no strobe, the beat count increases by one. After four advances, addr_o returns to the start address.
- R6: On an edge with advance_i low and no strobe, addr_o keeps its value.
- R7: A strobe takes priority over advance_i. A strobe in the middle of a burst reloads the address and restarts the beat count at zero.
- R8: addr_o above bit 1 changes only on an edge where a strobe is asserted.
- R9: mode_lin_i acts on addr_o within the same cycle, without a clock edge. The captured address and the beat count are not affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Start word address |
| strobe_proc_i | input | 1 | Processor-side load strobe |
| strobe_ctrl_i | input | 1 | Controller-side load strobe |
| advance_i | input | 1 | Step to the next beat |
| mode_lin_i | input | 1 | 1 = linear order, 0 = interleaved order |
| addr_o | output | ADDR_W | Current word address |

## Verification
Loading and advancing can be requested on the same edge. The bench tests this by asserting a strobe together with advance_i partway through a burst, in both orders and from each strobe source. It checks that the next cycle shows the new address at beat zero, not the old address one beat on. It then checks that the following advances step from the new start. A strobe with advance low during a hold, and both strobes together, are also covered.

// File: rtl/bam_pkg.sv
package bam_pkg;
  typedef enum logic {
    ORD_ILEAVE = 1'b0,
    ORD_LINEAR = 1'b1
  } ord_e;
endpackage

// File: rtl/bam_capture.sv
module bam_capture #(
  parameter int ADDR_W = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] base_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     base_o <= '0;
    else if (load_i) base_o <= addr_i;
  end
endmodule

// File: rtl/bam_beat_ctr.sv
module bam_beat_ctr #(
  parameter int BEAT_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              step_i,
  output logic [BEAT_W-1:0] beat_o
);
  localparam logic [BEAT_W-1:0] ONE = BEAT_W'(1);

  // clear wins over step
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      beat_o <= '0;
    else if (clear_i) beat_o <= '0;
    else if (step_i)  beat_o <= beat_o + ONE;
  end
endmodule

// File: rtl/bam_order.sv
module bam_order
  import bam_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  logic [BEAT_W-1:0] start_i,
  input  logic [BEAT_W-1:0] beat_i,
  input  ord_e              ord_i,
  output logic [BEAT_W-1:0] lo_o
);
  logic [BEAT_W-1:0] ilv;
  logic [BEAT_W-1:0] lin;

  for (genvar b = 0; b < BEAT_W; b++) begin : g_ilv
    assign ilv[b] = start_i[b] ^ beat_i[b];
  end

  // modulo 2**BEAT_W by truncation keeps the wrap inside the block
  assign lin  = start_i + beat_i;
  assign lo_o = (ord_i == ORD_LINEAR) ? lin : ilv;
endmodule

// File: rtl/bam_burst_addr.sv
module bam_burst_addr
  import bam_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int BEAT_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              strobe_proc_i,
  input  logic              strobe_ctrl_i,
  input  logic              advance_i,
  input  logic              mode_lin_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int HI_W = ADDR_W - BEAT_W;

  logic              load;
  logic [ADDR_W-1:0] base;
  logic [BEAT_W-1:0] beat;
  logic [BEAT_W-1:0] lo;
  ord_e              ord;

  assign load = strobe_proc_i | strobe_ctrl_i;
  assign ord  = ord_e'(mode_lin_i);

  bam_capture #(.ADDR_W(ADDR_W)) u_cap (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load),
    .addr_i(addr_i),
    .base_o(base)
  );

  bam_beat_ctr #(.BEAT_W(BEAT_W)) u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(load),
    .step_i (advance_i),
    .beat_o (beat)
  );

  bam_order #(.BEAT_W(BEAT_W)) u_ord (
    .start_i(base[BEAT_W-1:0]),
    .beat_i (beat),
    .ord_i  (ord),
    .lo_o   (lo)
  );

  assign addr_o = {base[ADDR_W-1 -: HI_W], lo};
endmodule

// File: rtl/bam_burst_addr_chk.sv
module bam_burst_addr_chk #(
  parameter int ADDR_W = 20,
  parameter int BEAT_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              strobe_proc_i,
  input logic              strobe_ctrl_i,
  input logic              advance_i,
  input logic              mode_lin_i,
  input logic [ADDR_W-1:0] addr_o
);
  logic              ld;
  logic [BEAT_W-1:0] st_q;
  logic [BEAT_W-1:0] cnt_q;
  logic [BEAT_W-1:0] lin_exp;

  assign ld      = strobe_proc_i | strobe_ctrl_i;
  assign lin_exp = st_q + cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= '0;
      cnt_q <= '0;
    end else if (ld) begin
      st_q  <= addr_i[BEAT_W-1:0];
      cnt_q <= '0;
    end else if (advance_i) begin
      cnt_q <= cnt_q + BEAT_W'(1);
    end
  end

  a_r1_reset_zero: assert property (@(posedge clk_i) !rst_ni |-> addr_o == '0);

  a_r2_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld |=> addr_o == $past(addr_i));

  a_r3_ileave: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_lin_i |-> addr_o[BEAT_W-1:0] == (st_q ^ cnt_q));

  a_r4_linear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_lin_i |-> addr_o[BEAT_W-1:0] == lin_exp);

  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ld && !advance_i) |=> ($stable(addr_o) || (mode_lin_i != $past(mode_lin_i))));

  a_r8_upper_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld |=> $stable(addr_o[ADDR_W-1:BEAT_W]));
endmodule

bind bam_burst_addr bam_burst_addr_chk #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_chk (.*);

// File: tb/bam_burst_addr_test.sv
module bam_burst_addr_test;
  localparam int AW = 20;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic          strobe_proc_i = 1'b0;
  logic          strobe_ctrl_i = 1'b0;
  logic          advance_i = 1'b0;
  logic          mode_lin_i = 1'b0;
  logic [AW-1:0] addr_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  bam_burst_addr #(.ADDR_W(AW), .BEAT_W(2)) uut (.*);

  function automatic logic [AW-1:0] exp_addr(logic [AW-1:0] st, int beat, bit lin);
    logic [1:0] b = 2'(beat);
    logic [1:0] lo = lin ? 2'(st[1:0] + b) : (st[1:0] ^ b);
    return {st[AW-1:2], lo};
  endfunction

  task automatic chk(string req, logic [AW-1:0] exp);
    checks++;
    if (addr_o !== exp) begin
      errors++;
      $display("FAIL %s addr_o=%h expected=%h", req, addr_o, exp);
    end
  endtask

  // inputs change 1 ns after the edge, outputs sampled there too
  task automatic step();
    @(posedge clk_i);
    #1;
  endtask

  task automatic idle();
    strobe_proc_i = 0; strobe_ctrl_i = 0; advance_i = 0;
  endtask

  task automatic load(logic [AW-1:0] a, bit ctrl, bit adv);
    addr_i = a; strobe_proc_i = !ctrl; strobe_ctrl_i = ctrl; advance_i = adv;
    step();
    idle();
  endtask

  task automatic t_reset();
    #3 chk("R1", '0);
    step(); rst_ni = 1'b1;
    step(); chk("R1", '0);
    step(); chk("R1", '0);
  endtask

  task automatic t_burst(logic [AW-1:0] st, bit lin, bit ctrl, string req);
    mode_lin_i = lin;
    load(st, ctrl, 1'b0);
    chk("R2", st);
    for (int k = 1; k <= 4; k++) begin
      advance_i = 1; step(); idle();
      chk(k == 4 ? "R5" : req, exp_addr(st, k, lin));
    end
  endtask

  task automatic t_hold();
    logic [AW-1:0] st = 20'hABCD2;
    mode_lin_i = 1;
    load(st, 1'b0, 1'b0);
    advance_i = 1; step(); idle();
    chk("R4", exp_addr(st, 1, 1));
    addr_i = 20'h55555;
    step(); chk("R6", exp_addr(st, 1, 1));
    step(); chk("R6", exp_addr(st, 1, 1));
    advance_i = 1; step(); idle();
    chk("R5", exp_addr(st, 2, 1));
  endtask

  task automatic t_restart(bit lin, bit ctrl);
    logic [AW-1:0] a = 20'h12341;
    logic [AW-1:0] b = 20'hFEDC3;
    mode_lin_i = lin;
    load(a, 1'b0, 1'b0);
    advance_i = 1; step(); step();
    chk("R5", exp_addr(a, 2, lin));
    load(b, ctrl, 1'b1);
    chk("R7", b);
    advance_i = 1; step(); idle();
    chk("R7", exp_addr(b, 1, lin));
    step(); chk("R8", exp_addr(b, 1, lin));
  endtask

  task automatic t_both_strobes();
    addr_i = 20'h0F0F2; strobe_proc_i = 1; strobe_ctrl_i = 1; advance_i = 0;
    step(); idle();
    chk("R2", 20'h0F0F2);
  endtask

  task automatic t_mode_switch();
    logic [AW-1:0] st = 20'h77771;
    mode_lin_i = 0;
    load(st, 1'b1, 1'b0);
    advance_i = 1; step(); idle();
    chk("R3", exp_addr(st, 1, 0));
    mode_lin_i = 1; #1;
    chk("R9", exp_addr(st, 1, 1));
    mode_lin_i = 0; #1;
    chk("R9", exp_addr(st, 1, 0));
  endtask

  initial begin
    t_reset();
    t_burst(20'h00001, 1'b0, 1'b0, "R3");
    t_burst(20'h00001, 1'b1, 1'b1, "R4");
    t_burst(20'h3C5A6, 1'b0, 1'b1, "R3");
    t_burst(20'h3C5A7, 1'b1, 1'b0, "R4");
    t_hold();
    t_restart(1'b0, 1'b0);
    t_restart(1'b1, 1'b1);
    t_both_strobes();
    t_mode_switch();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk_i);
        checks++; errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule